// File: doc/BRIEF.md
# Real-Time Buck Converter Plant Model

This block is a hardware-in-the-loop plant: it stands in for an asynchronous step-down converter, so a controller under test can be run against it in real time. A one-bit gate signal from the controller switches the model between two circuit states. In the on state the inductor sees the supply voltage. In the off state the inductor sees ground through a freewheeling diode. Each model step advances the inductor current and the capacitor voltage by one forward-Euler update in signed fixed point. The resistive load is part of the capacitor equation.

A clock-enable divider sets the step rate. Every step takes `OSR` clocks for each of `SOLVE_ITERS` solver phases. The first phase samples the gate and forms the inductor slope and the load current. The last phase forms the capacitor slope and commits both states. After each step, both states are scaled into signed 16-bit codes for a bipolar DAC and clamped to that range. A one-cycle strobe marks the cycle in which the new codes appear. A DAC conversion-enable output stays high so the converter samples at its full rate. The inductance, capacitance, load resistance, supply voltage, time step and output full-scale values are parameters.

Top module: `buck_plant`

## Requirements
- R1: While `rst` is high at a rising clock edge, both states, both DAC codes, `step_done` and the step divider return to zero.
- R2: After reset is released, steps repeat every `OSR*SOLVE_ITERS` clocks. `step_done` is high for exactly one cycle per step, and the new codes are valid in that same cycle.
- R3: `pwm_in` is sampled only at the end of the last clock of the first solver phase. Any pulse on it at another time has no effect on that step's result.
- R4: States are signed 32-bit values with 16 fraction bits. Gains are integers with 24 fraction bits: KL = floor(TS_NS·2^24/L_NH), KC = floor(TS_NS·2^24/C_NF), KG = floor(1000·2^24/R_MOHM). Every gain product is 64-bit and shifted right arithmetically by 24, with the result kept in 32 bits. The current updates as iL += (Vsw − vC)·KL, where Vsw = floor(VIN_MV·2^16/1000) with the switch on and 0 with it off.
- R5: With iR = (vC·KG) kept in 32 bits, the voltage updates as vC += (iL − iR)·KC. Both terms use the states from before the step.
- R6: With the switch off, an updated current that would be negative becomes exactly zero, which models diode blocking.
- R7: `i_code` = floor(iL·KI/2^32), where KI = floor(REF_MV·2^31/(I_FS_A·DAC_FS_MV)). With the defaults, 10 A maps to 3 V of a ±10 V output.
- R8: `v_code` = floor(vC·KV/2^32), where KV = floor(REF_MV·2^31/(V_FS_V·DAC_FS_MV)). With the defaults, 15 V maps to 3 V.
- R9: Codes saturate to the range −32768..32767 and never wrap.
- R10: `dac_trig` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Switch gate command, 1 = switch on |
| i_code | output | 16 | Signed DAC code for inductor current |
| v_code | output | 16 | Signed DAC code for output voltage |
| dac_trig | output | 1 | DAC conversion enable, tied high |
| step_done | output | 1 | One-cycle strobe: new codes valid |

## Verification
The bench computes its own fixed-point copy of the plant and tests four corner cases. It holds the switch off long enough for the current to cross zero. A design that lacks the diode clamp would then give negative current codes. It drives the switch on from rest until the current code passes full scale. A design that wraps instead of saturating would give a large negative code. In each step it pulses the gate to the wrong value away from the sample point. A design that samples the gate at the wrong time would take the wrong branch. It also measures the strobe period and width, and checks that a reset in the middle of a run clears the model.

// File: rtl/buck_pkg.sv
package buck_pkg;
  localparam int ST_W       = 32;  // state word width
  localparam int ST_FRAC    = 16;  // fraction bits of states
  localparam int GAIN_FRAC  = 24;  // fraction bits of step gains
  localparam int CODE_W     = 16;  // DAC code width
  localparam int SCALE_FRAC = 16;  // extra fraction bits of output scales

  typedef logic signed [ST_W-1:0]   state_t;
  typedef logic signed [CODE_W-1:0] code_t;
  typedef logic signed [63:0]       wide_t;

  localparam wide_t CODE_MAX = (64'sd1 <<< (CODE_W-1)) - 64'sd1;
  localparam wide_t CODE_MIN = -(64'sd1 <<< (CODE_W-1));

  function automatic code_t clamp_code(input wide_t v);
    if (v > CODE_MAX)      return code_t'(CODE_MAX);
    else if (v < CODE_MIN) return code_t'(CODE_MIN);
    else                   return code_t'(v);
  endfunction
endpackage

// File: rtl/buck_step_timer.sv
module buck_step_timer #(
  parameter int OSR         = 50,
  parameter int SOLVE_ITERS = 2
) (
  input  logic clk,
  input  logic rst,
  output logic sample_en,
  output logic commit_en
);
  localparam int OS_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int IT_W = (SOLVE_ITERS > 1) ? $clog2(SOLVE_ITERS) : 1;
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OSR - 1);
  localparam logic [IT_W-1:0] IT_LAST = IT_W'(SOLVE_ITERS - 1);

  logic [OS_W-1:0] os_cnt;
  logic [IT_W-1:0] it_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      os_cnt <= '0;
      it_cnt <= '0;
    end else if (os_cnt == OS_LAST) begin
      os_cnt <= '0;
      it_cnt <= (it_cnt == IT_LAST) ? '0 : it_cnt + 1'b1;
    end else begin
      os_cnt <= os_cnt + 1'b1;
    end
  end

  assign sample_en = (os_cnt == OS_LAST) && (it_cnt == '0);
  assign commit_en = (os_cnt == OS_LAST) && (it_cnt == IT_LAST);

  // R2
  phase_order_chk: assert property (@(posedge clk) disable iff (rst)
    commit_en |=> !commit_en);
endmodule

// File: rtl/buck_state_update.sv
module buck_state_update
  import buck_pkg::*;
#(
  parameter longint KL    = 0,
  parameter longint KC    = 0,
  parameter longint KG    = 0,
  parameter longint VIN_Q = 0
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   pwm,
  input  logic   sample_en,
  input  logic   commit_en,
  output state_t il_q,
  output state_t vc_q
);
  logic   sw_q;
  state_t d_il_q;
  state_t ir_q;

  wide_t  vsw;
  wide_t  d_il_w;
  wide_t  ir_w;
  wide_t  d_vc_w;
  state_t il_next;

  // phase 0: inductor slope and load current from the pre-step states
  always_comb begin
    vsw    = pwm ? wide_t'(VIN_Q) : 64'sd0;
    d_il_w = ((vsw - wide_t'(vc_q)) * KL) >>> GAIN_FRAC;
    ir_w   = (wide_t'(vc_q) * KG) >>> GAIN_FRAC;
  end

  // last phase: capacitor slope and diode-aware current
  always_comb begin
    d_vc_w  = ((wide_t'(il_q) - wide_t'(ir_q)) * KC) >>> GAIN_FRAC;
    il_next = il_q + d_il_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q   <= 1'b0;
      d_il_q <= '0;
      ir_q   <= '0;
      il_q   <= '0;
      vc_q   <= '0;
    end else begin
      if (sample_en) begin
        sw_q   <= pwm;
        d_il_q <= state_t'(d_il_w);
        ir_q   <= state_t'(ir_w);
      end
      if (commit_en) begin
        il_q <= (!sw_q && il_next[ST_W-1]) ? '0 : il_next;
        vc_q <= vc_q + state_t'(d_vc_w);
      end
    end
  end

  // R6
  diode_block_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_en && !sw_q) |=> !il_q[ST_W-1]);

  // R1
  state_clear_chk: assert property (@(posedge clk)
    rst |=> (il_q == '0 && vc_q == '0));
endmodule

// File: rtl/buck_dac_scale.sv
module buck_dac_scale
  import buck_pkg::*;
#(
  parameter longint KI = 0,
  parameter longint KV = 0
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  state_t il,
  input  state_t vc,
  output code_t  i_code,
  output code_t  v_code
);
  localparam int SHIFT = ST_FRAC + SCALE_FRAC;

  wide_t i_scaled;
  wide_t v_scaled;

  always_comb begin
    i_scaled = (wide_t'(il) * KI) >>> SHIFT;
    v_scaled = (wide_t'(vc) * KV) >>> SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      i_code <= '0;
      v_code <= '0;
    end else if (load) begin
      i_code <= clamp_code(i_scaled);
      v_code <= clamp_code(v_scaled);
    end
  end

  // R9
  code_top_chk: assert property (@(posedge clk) disable iff (rst)
    (load && i_scaled > CODE_MAX) |=> (i_code == code_t'(CODE_MAX)));

  // R7
  code_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !il[ST_W-1]) |=> !i_code[CODE_W-1]);
endmodule

// File: rtl/buck_plant.sv
module buck_plant
  import buck_pkg::*;
#(
  parameter int OSR         = 50,
  parameter int SOLVE_ITERS = 2,
  parameter int TS_NS       = 1000,
  parameter int L_NH        = 100000,
  parameter int C_NF        = 100000,
  parameter int R_MOHM      = 5000,
  parameter int VIN_MV      = 15000,
  parameter int I_FS_A      = 10,
  parameter int V_FS_V      = 15,
  parameter int REF_MV      = 3000,
  parameter int DAC_FS_MV   = 10000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pwm_in,
  output logic [15:0] i_code,
  output logic [15:0] v_code,
  output logic        dac_trig,
  output logic        step_done
);
  localparam longint VIN_Q = (longint'(VIN_MV) <<< ST_FRAC) / 1000;
  localparam longint KL    = (longint'(TS_NS) <<< GAIN_FRAC) / L_NH;
  localparam longint KC    = (longint'(TS_NS) <<< GAIN_FRAC) / C_NF;
  localparam longint KG    = (longint'(1000) <<< GAIN_FRAC) / R_MOHM;
  localparam longint KI    = (longint'(REF_MV) <<< (CODE_W - 1 + SCALE_FRAC))
                             / (longint'(I_FS_A) * DAC_FS_MV);
  localparam longint KV    = (longint'(REF_MV) <<< (CODE_W - 1 + SCALE_FRAC))
                             / (longint'(V_FS_V) * DAC_FS_MV);

  logic   sample_en;
  logic   commit_en;
  logic   commit_q;
  state_t il_q;
  state_t vc_q;
  code_t  i_code_s;
  code_t  v_code_s;

  buck_step_timer #(.OSR(OSR), .SOLVE_ITERS(SOLVE_ITERS)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .commit_en (commit_en)
  );

  buck_state_update #(.KL(KL), .KC(KC), .KG(KG), .VIN_Q(VIN_Q)) u_state (
    .clk       (clk),
    .rst       (rst),
    .pwm       (pwm_in),
    .sample_en (sample_en),
    .commit_en (commit_en),
    .il_q      (il_q),
    .vc_q      (vc_q)
  );

  buck_dac_scale #(.KI(KI), .KV(KV)) u_dac (
    .clk    (clk),
    .rst    (rst),
    .load   (commit_q),
    .il     (il_q),
    .vc     (vc_q),
    .i_code (i_code_s),
    .v_code (v_code_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_q  <= 1'b0;
      step_done <= 1'b0;
    end else begin
      commit_q  <= commit_en;
      step_done <= commit_q;
    end
  end

  assign i_code   = i_code_s;
  assign v_code   = v_code_s;
  assign dac_trig = 1'b1;

  // R2
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    step_done |=> !step_done);

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    commit_q |=> step_done);
endmodule

// File: tb/tb_buck_plant.sv
module tb_buck_plant;
  localparam int OSR       = 3;
  localparam int ITERS     = 2;
  localparam int TS_NS     = 1000;
  localparam int L_NH      = 10000;
  localparam int C_NF      = 20000;
  localparam int R_MOHM    = 2000;
  localparam int VIN_MV    = 15000;
  localparam int I_FS_A    = 1;
  localparam int V_FS_V    = 15;
  localparam int REF_MV    = 3000;
  localparam int DAC_FS_MV = 10000;

  localparam longint VIN_Q = (longint'(VIN_MV) * 65536) / 1000;
  localparam longint KL = (longint'(TS_NS) * (64'sd1 <<< 24)) / L_NH;
  localparam longint KC = (longint'(TS_NS) * (64'sd1 <<< 24)) / C_NF;
  localparam longint KG = (longint'(1000) * (64'sd1 <<< 24)) / R_MOHM;
  localparam longint KI = (longint'(REF_MV) * (64'sd1 <<< 31)) / (longint'(I_FS_A) * DAC_FS_MV);
  localparam longint KV = (longint'(REF_MV) * (64'sd1 <<< 31)) / (longint'(V_FS_V) * DAC_FS_MV);

  // run-length stimulus table: bit 7 = switch state, bits 6:0 = step count
  localparam int NRUNS = 8;
  localparam logic [7:0] RUNS [NRUNS] = '{
    {1'b1, 7'd3}, {1'b0, 7'd37}, {1'b1, 7'd1}, {1'b0, 7'd1},
    {1'b1, 7'd2}, {1'b0, 7'd1},  {1'b1, 7'd12}, {1'b0, 7'd4}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwm_in = 1'b0;
  logic [15:0] i_code;
  logic [15:0] v_code;
  logic        dac_trig;
  logic        step_done;

  int total = 0;
  int bad = 0;
  int m_il = 0;
  int m_vc = 0;
  bit m_clamped = 0;
  int cyc = 0;

  buck_plant #(
    .OSR(OSR), .SOLVE_ITERS(ITERS), .TS_NS(TS_NS), .L_NH(L_NH), .C_NF(C_NF),
    .R_MOHM(R_MOHM), .VIN_MV(VIN_MV), .I_FS_A(I_FS_A), .V_FS_V(V_FS_V),
    .REF_MV(REF_MV), .DAC_FS_MV(DAC_FS_MV)
  ) dut (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .i_code(i_code), .v_code(v_code),
    .dac_trig(dac_trig), .step_done(step_done)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint raw_code(input int st, input longint k);
    return (longint'(st) * k) >>> 32;
  endfunction

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_step(input bit sw);
    longint vsw = sw ? VIN_Q : 0;
    int dil = int'(((vsw - longint'(m_vc)) * KL) >>> 24);
    int ir  = int'((longint'(m_vc) * KG) >>> 24);
    int dvc = int'(((longint'(m_il) - longint'(ir)) * KC) >>> 24);
    int nil = m_il + dil;
    m_clamped = 0;
    if (!sw && nil < 0) begin
      nil = 0;
      m_clamped = 1;
    end
    m_vc = m_vc + dvc;
    m_il = nil;
  endtask

  // first: the step right after reset release, no gate pulse and no period check
  task automatic do_step(input bit sw, input bit first);
    int n = 0;
    longint ri;
    if (!first) begin
      // R3: wrong gate value away from the sample edge
      pwm_in = ~sw;
      @(negedge clk);
      n = 1;
      chk("R2 strobe width", step_done, 0);
      pwm_in = sw;
    end
    do begin
      @(negedge clk);
      n++;
    end while (!step_done && n < 100);
    if (n >= 100) begin
      chk("R2 watchdog step", n, 2 * OSR);
    end else begin
      model_step(sw);
      if (!first) chk("R2 step period", n, OSR * ITERS);
      ri = raw_code(m_il, KI);
      if (ri > 32767)     chk("R9 saturation", longint'($signed(i_code)), 32767);
      else if (m_clamped) chk("R6 diode clamp", longint'($signed(i_code)), 0);
      else                chk("R3 R4 R7 current code", longint'($signed(i_code)), sat16(ri));
      chk("R5 R8 voltage code", longint'($signed(v_code)), sat16(raw_code(m_vc, KV)));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int saw_sat = 0;
    int saw_clamp = 0;
    bit first = 1;
    pwm_in = RUNS[0][7];
    repeat (3) @(negedge clk);
    // R1 reset state, R10 trigger
    chk("R1 reset i_code", longint'($signed(i_code)), 0);
    chk("R1 reset v_code", longint'($signed(v_code)), 0);
    chk("R1 reset strobe", step_done, 0);
    chk("R10 trigger high", dac_trig, 1);
    rst = 1'b0;

    for (int r = 0; r < NRUNS; r++) begin
      for (int s = 0; s < int'(RUNS[r][6:0]); s++) begin
        do_step(RUNS[r][7], first);
        first = 0;
        if (m_clamped) saw_clamp++;
        if (raw_code(m_il, KI) > 32767) saw_sat++;
      end
    end
    chk("R6 clamp reached", longint'(saw_clamp > 0), 1);
    chk("R9 saturation reached", longint'(saw_sat > 0), 1);

    // mid-run reset clears the model (R1)
    @(negedge clk);
    rst = 1'b1;
    pwm_in = 1'b1;
    @(negedge clk);
    chk("R1 mid-run i_code", longint'($signed(i_code)), 0);
    chk("R1 mid-run v_code", longint'($signed(v_code)), 0);
    chk("R1 mid-run strobe", step_done, 0);
    @(negedge clk);
    m_il = 0;
    m_vc = 0;
    rst = 1'b0;
    do_step(1'b1, 1'b1);
    do_step(1'b1, 1'b0);
    do_step(1'b0, 1'b0);
    do_step(1'b0, 1'b0);
    chk("R10 trigger after run", dac_trig, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule